// File: doc/BRIEF.md
# Shadowed PWM Time-Base and Compare Unit

This block holds the timing core of a pulse-width modulator: a time-base counter that either climbs from zero to a period value and wraps, or climbs to the period and falls back to zero. Two compare channels, A and B, watch the counter. It emits one-clock event strobes that a later output-action stage can turn into PWM edges. These strobes mark a zero count, a period count, and a match on each channel. Each match strobe is split by counting direction.

The period and both compare values pass through shadow registers. Software, or an upstream controller, may change the inputs at any time. For each channel, a select input chooses when the shadow value becomes active: at the zero point, at the period point, or at once (direct). The period moves at the zero point, or at once when its direct bit is set. Because of this, a value that changes part-way through a cycle never distorts the cycle in progress.

Top module: `pwm_tbcmp`

## Requirements
- R1: With `mode_ud`=0 (up mode) and `tick_en` held high, `cnt` steps 0,1,…,P and then returns to 0. Zero strobes are therefore P+1 clocks apart; P is the active period.
- R2: With `mode_ud`=1 (up-down mode), `cnt` rises to P with `dir_up`=1. On the tick taken at P it turns and falls with `dir_up`=0. On the tick taken at 0 it turns up again. Zero strobes are 2·P clocks apart.
- R3: A clock with `tick_en`=0 leaves `cnt` and `dir_up` unchanged, and no strobe follows it. Every strobe is high for exactly one clock, the clock after the tick that caused it.
- R4: Compare select 2'b00 moves the shadow into the active compare on the tick at count 0; select 2'b01 does so on the tick at count P. A compare input changed mid-cycle leaves the current cycle's matches at the old value.
- R5: Compare select 2'b10 or 2'b11 (direct) makes the active compare equal the input one clock after it is applied.
- R6: With `prd_direct`=0, a new period input takes effect only on the tick at count 0. With `prd_direct`=1, it takes effect one clock after it is applied.
- R7: A match of count and active compare raises the up strobe (`ev_a_up`/`ev_b_up`) if `dir_up` was 1 at that tick, and otherwise the down strobe. In up mode only up strobes occur.
- R8: `ev_zero` and `ev_prd` each fire once per turn: once per cycle in either mode.
- R9: While `rst` is high, `cnt` becomes 0, `dir_up` becomes 1 and all strobes go low. The shadow and active registers take the present period and compare inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable |
| mode_ud | input | 1 | 0 = up count, 1 = up-down count |
| prd_in | input | W | Period value (shadow input) |
| prd_direct | input | 1 | 1 = period bypasses its shadow |
| cmpa_in | input | W | Channel A compare value |
| cmpb_in | input | W | Channel B compare value |
| a_load_sel | input | 2 | A transfer point: 00 zero, 01 period, 1x direct |
| b_load_sel | input | 2 | B transfer point: 00 zero, 01 period, 1x direct |
| cnt | output | W | Time-base count |
| dir_up | output | 1 | 1 while counting up |
| ev_zero | output | 1 | Strobe: count was 0 |
| ev_prd | output | 1 | Strobe: count was the period |
| ev_a_up | output | 1 | Strobe: A match while counting up |
| ev_a_dn | output | 1 | Strobe: A match while counting down |
| ev_b_up | output | 1 | Strobe: B match while counting up |
| ev_b_dn | output | 1 | Strobe: B match while counting down |

## Verification
The assertions assume a period of at least 1 in up-down mode, and that the bench keeps its inputs stable across each rising edge. The stimulus uses periods between 4 and 10, with compare values from 0 up to the period. It changes inputs only on falling edges. The mode changes only while a fresh cycle is being settled, and a few discarded cycles follow each change before any directed measurement. A behavioural model is compared on every clock, and this covers the mode-switch transients.

// File: rtl/pwm_tbcmp_pkg.sv
package pwm_tbcmp_pkg;
  // Transfer point of a shadowed register
  typedef enum logic [1:0] {
    LD_ZERO   = 2'b00,
    LD_PRD    = 2'b01,
    LD_DIRECT = 2'b10
  } ld_sel_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         mode_ud,
  input  logic [W-1:0] prd_act,
  output logic [W-1:0] cnt,
  output logic         dir_up,
  output logic         at_zero,
  output logic         at_prd,
  output logic         ev_zero,
  output logic         ev_prd
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_nx;
  logic         dir_nx;

  assign at_zero = (cnt == '0);
  assign at_prd  = (cnt == prd_act);

  always_comb begin
    cnt_nx = cnt;
    dir_nx = dir_up;
    if (!mode_ud) begin
      dir_nx = 1'b1;
      cnt_nx = (cnt >= prd_act) ? '0 : cnt + ONE;
    end else if (prd_act == '0) begin
      dir_nx = 1'b1;
      cnt_nx = '0;
    end else if (dir_up) begin
      if (cnt >= prd_act) begin
        dir_nx = 1'b0;
        cnt_nx = cnt - ONE;
      end else begin
        cnt_nx = cnt + ONE;
      end
    end else begin
      if (at_zero) begin
        dir_nx = 1'b1;
        cnt_nx = ONE;
      end else begin
        cnt_nx = cnt - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      dir_up  <= 1'b1;
      ev_zero <= 1'b0;
      ev_prd  <= 1'b0;
    end else begin
      ev_zero <= tick & at_zero;
      ev_prd  <= tick & at_prd;
      if (tick) begin
        cnt    <= cnt_nx;
        dir_up <= dir_nx;
      end
    end
  end
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_tbcmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         at_zero,
  input  logic         at_prd,
  input  logic [1:0]   sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] act
);
  logic [W-1:0] shd;
  logic         xfer;

  always_comb begin
    unique case (sel)
      LD_ZERO: xfer = tick & at_zero;
      LD_PRD:  xfer = tick & at_prd;
      default: xfer = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    shd <= din;
    if (rst) begin
      act <= din;
    end else if (sel[1]) begin
      act <= din;
    end else if (xfer) begin
      act <= shd;
    end
  end
endmodule

// File: rtl/pwm_match.sv
module pwm_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         dir_up,
  input  logic [W-1:0] cmp_act,
  output logic         ev_up,
  output logic         ev_dn
);
  logic hit;
  assign hit = tick & (cnt == cmp_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_up <= 1'b0;
      ev_dn <= 1'b0;
    end else begin
      ev_up <= hit & dir_up;
      ev_dn <= hit & ~dir_up;
    end
  end
endmodule

// File: rtl/pwm_tbcmp.sv
module pwm_tbcmp
  import pwm_tbcmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         mode_ud,
  input  logic [W-1:0] prd_in,
  input  logic         prd_direct,
  input  logic [W-1:0] cmpa_in,
  input  logic [W-1:0] cmpb_in,
  input  logic [1:0]   a_load_sel,
  input  logic [1:0]   b_load_sel,
  output logic [W-1:0] cnt,
  output logic         dir_up,
  output logic         ev_zero,
  output logic         ev_prd,
  output logic         ev_a_up,
  output logic         ev_a_dn,
  output logic         ev_b_up,
  output logic         ev_b_dn
);
  logic [W-1:0] prd_act;
  logic         at_zero, at_prd;
  logic [1:0]   prd_sel;

  logic [W-1:0] ch_din [NUM_CH];
  logic [1:0]   ch_sel [NUM_CH];
  logic [W-1:0] ch_act [NUM_CH];
  logic         ch_up  [NUM_CH];
  logic         ch_dn  [NUM_CH];

  assign prd_sel   = prd_direct ? LD_DIRECT : LD_ZERO;
  assign ch_din[0] = cmpa_in;
  assign ch_din[1] = cmpb_in;
  assign ch_sel[0] = a_load_sel;
  assign ch_sel[1] = b_load_sel;

  pwm_shadow #(.W(W)) u_prd_shd (
    .clk(clk), .rst(rst), .tick(tick_en), .at_zero(at_zero), .at_prd(at_prd),
    .sel(prd_sel), .din(prd_in), .act(prd_act)
  );

  pwm_tb_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_en), .mode_ud(mode_ud), .prd_act(prd_act),
    .cnt(cnt), .dir_up(dir_up), .at_zero(at_zero), .at_prd(at_prd),
    .ev_zero(ev_zero), .ev_prd(ev_prd)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_shadow #(.W(W)) u_shd (
      .clk(clk), .rst(rst), .tick(tick_en), .at_zero(at_zero), .at_prd(at_prd),
      .sel(ch_sel[g]), .din(ch_din[g]), .act(ch_act[g])
    );
    pwm_match #(.W(W)) u_match (
      .clk(clk), .rst(rst), .tick(tick_en), .cnt(cnt), .dir_up(dir_up),
      .cmp_act(ch_act[g]), .ev_up(ch_up[g]), .ev_dn(ch_dn[g])
    );
  end

  assign ev_a_up = ch_up[0];
  assign ev_a_dn = ch_dn[0];
  assign ev_b_up = ch_up[1];
  assign ev_b_dn = ch_dn[1];
endmodule

// File: rtl/pwm_tbcmp_chk.sv
module pwm_tbcmp_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick_en,
  input logic         mode_ud,
  input logic [W-1:0] cnt,
  input logic         dir_up,
  input logic         ev_zero,
  input logic         ev_prd,
  input logic         ev_a_up,
  input logic         ev_a_dn,
  input logic         ev_b_up,
  input logic         ev_b_dn
);
  logic any_ev;
  assign any_ev = ev_zero | ev_prd | ev_a_up | ev_a_dn | ev_b_up | ev_b_dn;

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> ($stable(cnt) && $stable(dir_up)));

  // R3
  strobe_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    any_ev |-> $past(tick_en));

  // R7
  a_dir_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ev_a_up && ev_a_dn));

  // R7
  a_dn_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_a_dn || ev_b_dn) |-> !$past(dir_up));

  // R7
  up_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_a_up || ev_b_up) |-> $past(dir_up));

  // R8
  zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    ev_zero |-> ($past(cnt) == '0));

  // R2
  up_mode_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_ud && tick_en) |=> dir_up);

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt == '0 && dir_up && !any_ev));
endmodule

bind pwm_tbcmp pwm_tbcmp_chk #(.W(W)) u_chk (.*);

// File: tb/tb_pwm_tbcmp.sv
module tb_pwm_tbcmp;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_en = 1'b1;
  logic         mode_ud = 1'b0;
  logic [W-1:0] prd_in = 16'd10;
  logic         prd_direct = 1'b0;
  logic [W-1:0] cmpa_in = 16'd3;
  logic [W-1:0] cmpb_in = 16'd7;
  logic [1:0]   a_load_sel = 2'b00;
  logic [1:0]   b_load_sel = 2'b00;
  logic [W-1:0] cnt;
  logic         dir_up, ev_zero, ev_prd, ev_a_up, ev_a_dn, ev_b_up, ev_b_dn;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_tbcmp #(.W(W)) dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_cnt, m_up, m_p, m_a, m_b, m_sp, m_sa, m_sb;
  int m_ez, m_ep, m_au, m_ad, m_bu, m_bd;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_cnt = 0; m_up = 1;
      m_p = int'(prd_in); m_a = int'(cmpa_in); m_b = int'(cmpb_in);
      m_ez = 0; m_ep = 0; m_au = 0; m_ad = 0; m_bu = 0; m_bd = 0;
    end else begin
      int old_p;
      bit z, p;
      old_p = m_p;
      z = (m_cnt == 0);
      p = (m_cnt == old_p);
      m_ez = tick_en && z;
      m_ep = tick_en && p;
      m_au = tick_en && (m_cnt == m_a) && m_up == 1;
      m_ad = tick_en && (m_cnt == m_a) && m_up == 0;
      m_bu = tick_en && (m_cnt == m_b) && m_up == 1;
      m_bd = tick_en && (m_cnt == m_b) && m_up == 0;
      if (tick_en) begin
        if (!mode_ud) begin
          m_up = 1;
          m_cnt = (m_cnt >= old_p) ? 0 : m_cnt + 1;
        end else if (old_p == 0) begin
          m_up = 1; m_cnt = 0;
        end else if (m_up == 1) begin
          if (m_cnt >= old_p) begin m_up = 0; m_cnt = m_cnt - 1; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_up = 1; m_cnt = 1; end
          else m_cnt = m_cnt - 1;
        end
        if (a_load_sel == 2'b00 && z) m_a = m_sa;
        if (a_load_sel == 2'b01 && p) m_a = m_sa;
        if (b_load_sel == 2'b00 && z) m_b = m_sb;
        if (b_load_sel == 2'b01 && p) m_b = m_sb;
        if (!prd_direct && z) m_p = m_sp;
      end
      if (a_load_sel[1]) m_a = int'(cmpa_in);
      if (b_load_sel[1]) m_b = int'(cmpb_in);
      if (prd_direct) m_p = int'(prd_in);
    end
    m_sp = int'(prd_in); m_sa = int'(cmpa_in); m_sb = int'(cmpb_in);
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check("R1 count", int'(cnt), m_cnt);
      check("R2 direction", int'(dir_up), m_up);
      check("R8 zero strobe", int'(ev_zero), m_ez);
      check("R8 period strobe", int'(ev_prd), m_ep);
      check("R7 A up", int'(ev_a_up), m_au);
      check("R7 A down", int'(ev_a_dn), m_ad);
      check("R7 B up", int'(ev_b_up), m_bu);
      check("R7 B down", int'(ev_b_dn), m_bd);
    end
  end

  // Step until a zero strobe; report clocks, A strobes, last A position, period strobes
  task automatic run_cycle(output int clks, output int na_up, output int na_dn,
                           output int a_pos, output int nprd);
    clks = 0; na_up = 0; na_dn = 0; a_pos = -1; nprd = 0;
    forever begin
      @(negedge clk);
      clks++;
      if (ev_a_up) begin na_up++; a_pos = int'(cnt) - 1; end
      if (ev_a_dn) na_dn++;
      if (ev_prd) nprd++;
      if (ev_zero || clks > 1000) break;
    end
  endtask

  task automatic wait_cnt(input int v);
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (int'(cnt) == v) break;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c, au, ad, pos, np;
    int held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state, seen before the first tick after release
    check("R9 cnt", int'(cnt), 0);
    check("R9 dir", int'(dir_up), 1);
    check("R9 strobes", int'(ev_zero | ev_prd | ev_a_up | ev_b_up), 0);

    // R1 up mode, period 10
    run_cycle(c, au, ad, pos, np);
    run_cycle(c, au, ad, pos, np);
    check("R1 cycle clocks", c, 11);
    check("R9 A position from reset-loaded compare", pos, 3);

    // R3 idle ticks
    wait_cnt(4);
    tick_en = 1'b0;
    held = int'(cnt);
    repeat (5) begin
      @(negedge clk);
      check("R3 held count", int'(cnt), held);
      check("R3 no strobe", int'(ev_zero | ev_prd | ev_a_up | ev_b_up), 0);
    end
    tick_en = 1'b1;
    run_cycle(c, au, ad, pos, np);

    // R4 shadow at zero: mid-cycle write waits for the next cycle
    wait_cnt(5);
    cmpa_in = 16'd8;
    run_cycle(c, au, ad, pos, np);
    check("R4 no A strobe in current cycle", au, 0);
    run_cycle(c, au, ad, pos, np);
    check("R4 A strobe count next cycle", au, 1);
    check("R4 A position next cycle", pos, 8);

    // R5 direct compare
    a_load_sel = 2'b10;
    wait_cnt(2);
    cmpa_in = 16'd6;
    run_cycle(c, au, ad, pos, np);
    check("R5 direct A position", pos, 6);
    check("R5 direct A count", au, 1);

    // R4 load at period
    a_load_sel = 2'b01;
    run_cycle(c, au, ad, pos, np);
    wait_cnt(2);
    cmpa_in = 16'd4;
    run_cycle(c, au, ad, pos, np);
    check("R4 period-load A position", pos, 6);
    run_cycle(c, au, ad, pos, np);
    check("R4 period-load next position", pos, 4);

    // R6 shadowed period
    a_load_sel = 2'b00;
    wait_cnt(3);
    prd_in = 16'd5;
    run_cycle(c, au, ad, pos, np);
    check("R6 old period finishes", c, 9);
    run_cycle(c, au, ad, pos, np);
    check("R6 new period cycle", c, 6);

    // R6 direct period
    prd_direct = 1'b1;
    prd_in = 16'd8;
    run_cycle(c, au, ad, pos, np);
    wait_cnt(2);
    prd_in = 16'd4;
    run_cycle(c, au, ad, pos, np);
    check("R6 direct period remainder", c, 4);
    prd_direct = 1'b0;

    // R2/R7/R8 up-down mode, period 10, A = 3
    prd_in = 16'd10;
    cmpa_in = 16'd3;
    mode_ud = 1'b1;
    repeat (3) run_cycle(c, au, ad, pos, np);
    run_cycle(c, au, ad, pos, np);
    check("R2 up-down cycle clocks", c, 20);
    check("R7 A up strobes per cycle", au, 1);
    check("R7 A down strobes per cycle", ad, 1);
    check("R8 period strobes per cycle", np, 1);

    // Irregular tick pattern, varied compares, checked by the model
    cmpb_in = 16'd10;
    b_load_sel = 2'b01;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      tick_en = (i % 3) != 1;
      if (i % 97 == 0) cmpa_in = 16'(i % 10);
      if (i == 200) mode_ud = 1'b0;
    end
    tick_en = 1'b1;
    repeat (30) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule